// File: doc/BRIEF.md
# MII Transmit Start Gate

This block decides the cycle in which a transmit port may begin a frame. It holds the port idle until every start condition is met together: software has set the port's enable, the transmit FIFO holds at least one nibble, the minimum gap since the previous frame has elapsed, and the cut-through delay armed by the associated receive path's `rx_dv` has run out. When self-clear mode is selected, an external compare-match permit is also required. It then raises `tx_en`, pulses a start strobe and reads the FIFO one nibble per cycle until it consumes the nibble that carries the end-of-frame marker.

With automatic preamble selected, the block emits sixteen generated nibbles before the first FIFO read: fifteen of value 0x5 followed by 0xD. Generation does not begin until data is present in the FIFO, so the preamble is never produced ahead of the first write. In self-clear mode, the end of each frame produces a one-cycle enable-clear pulse, which the register that owns the enable bit uses to clear it. All control outputs except the FIFO read strobe are registered.

Top module: `mii_tx_start_gate`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `tx_en`, `tx_start`, `pre_sel`, `en_clr` and `fifo_rd` are 0 and `pre_nibble` is 0. The gap counter counts as expired and the start delay counts as run out.
- R2: A rising edge of `rx_dv` sampled at clock edge k, with `start_dly` = D, blocks a start at edge k and at the D edges that follow. The earliest start is edge k+D+1.
- R3: No start occurs while `fifo_empty` is 1. If every other condition is met, the start happens at the first edge that samples `fifo_empty` = 0.
- R4: If `tx_en` falls at edge e and `min_ipg` = G, `tx_en` cannot rise before edge e+G. When all other conditions are met it rises exactly at e+G.
- R5: No start occurs while `tx_enable` is 0. If `tx_enable` is dropped during a frame, `fifo_rd` goes low in the same cycle and `tx_en` falls at the next edge.
- R6: When `self_clr_mode` = 1, no start occurs while `cmp_permit` = 0. When `self_clr_mode` = 0, `cmp_permit` has no effect.
- R7: When `self_clr_mode` = 1, `en_clr` is high for exactly one cycle, registered at the same edge at which `tx_en` falls on end of frame. When `self_clr_mode` = 0, `en_clr` never rises.
- R8: The frame ends, and `tx_en` falls, at the edge that reads a FIFO nibble with `fifo_eof` = 1. One nibble is read per cycle in which `fifo_rd` is high.
- R9: With `auto_pre_en` = 1, `pre_sel` is high for exactly 16 cycles starting with the first `tx_en` cycle. `pre_nibble` is 0x5 for the first 15 of those cycles and 0xD for the last. `fifo_rd` stays low throughout these cycles.
- R10: `tx_start` is a one-cycle pulse that coincides with the first cycle of `tx_en`.
- R11: With `auto_pre_en` = 0, `pre_sel` stays low and FIFO reads begin in the first `tx_en` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Port enable bit from the configuration register |
| self_clr_mode | input | 1 | Enable clears itself at end of frame; also requires the permit |
| auto_pre_en | input | 1 | Insert generated preamble and SFD ahead of FIFO data |
| start_dly | input | CNT_W | Start delay in core cycles after rx_dv rises |
| min_ipg | input | CNT_W | Minimum idle cycles between frames |
| rx_dv | input | 1 | Data-valid of the associated receive path |
| cmp_permit | input | 1 | External compare-match start permit |
| fifo_empty | input | 1 | Transmit FIFO holds no nibble |
| fifo_eof | input | 1 | FIFO head nibble carries the end-of-frame marker |
| tx_en | output | 1 | Frame active on the transmit port |
| tx_start | output | 1 | One-cycle strobe at frame start |
| fifo_rd | output | 1 | Pop one nibble from the FIFO at the next edge |
| pre_sel | output | 1 | Current nibble comes from the preamble generator |
| pre_nibble | output | NIB_W | Generated preamble/SFD nibble |
| en_clr | output | 1 | One-cycle request to clear the enable bit |

## Verification
Every registered result is due one edge after the inputs that cause it, with these exceptions: `tx_en` rises D+1 edges after an `rx_dv` rise and G edges after its own fall, and the first FIFO read follows a start after 16 cycles of preamble or in the start cycle itself. The `fifo_rd` strobe is combinational and is due in the same cycle as the state and inputs that produce it. The bench drives inputs at the falling edge and samples outputs shortly after it. A behavioural model, advanced at each rising edge, therefore produces the value that the block must already show at the sample point. Directed checks count whole sample periods between a stimulus and the observed effect, and compare that count with the latencies above.

// File: rtl/mtg_pkg.sv
package mtg_pkg;
  typedef enum logic [1:0] {
    GATE_IDLE = 2'd0,
    GATE_PRE  = 2'd1,
    GATE_DATA = 2'd2
  } gate_state_e;
endpackage

// File: rtl/mtg_delay_timer.sv
// Cut-through start delay: armed by a rising rx_dv, counts down to zero.
module mtg_delay_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_dv,
  input  logic [CNT_W-1:0] dly_cfg,
  output logic             dv_rise,
  output logic             expired
);
  logic             dv_q;
  logic [CNT_W-1:0] remain;

  assign dv_rise = rx_dv & ~dv_q;
  assign expired = (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q   <= 1'b0;
      remain <= '0;
    end else begin
      dv_q <= rx_dv;
      if (dv_rise) begin
        remain <= dly_cfg;
      end else if (remain != '0) begin
        remain <= remain - 1'b1;
      end
    end
  end

  // R2
  dly_countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (!dv_rise && !expired) |=> (remain == $past(remain) - 1'b1));
endmodule

// File: rtl/mtg_ipg_timer.sv
// Idle-gap counter: cleared while the port transmits, saturates at the programmed gap.
module mtg_ipg_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en_nxt,
  input  logic [CNT_W-1:0] ipg_cfg,
  output logic             expired
);
  logic [CNT_W-1:0] gap_cnt;

  assign expired = (gap_cnt >= ipg_cfg);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '1;
    end else if (tx_en_nxt) begin
      gap_cnt <= '0;
    end else if (gap_cnt < ipg_cfg) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  // R4
  ipg_stays_open_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_en_nxt && expired) |=> (expired || (ipg_cfg != $past(ipg_cfg))));
endmodule

// File: rtl/mtg_preamble.sv
// Generated preamble: PRE_LEN-1 filler nibbles then one delimiter nibble.
module mtg_preamble #(
  parameter int          NIB_W   = 4,
  parameter int          PRE_LEN = 16,
  parameter logic [3:0]  PRE_NIB = 4'h5,
  parameter logic [3:0]  SFD_NIB = 4'hD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             abort,
  output logic             active,
  output logic [NIB_W-1:0] nibble,
  output logic             last
);
  localparam int               IDX_W   = $clog2(PRE_LEN);
  localparam logic [IDX_W-1:0] LAST_IX = IDX_W'(PRE_LEN - 1);
  localparam logic [IDX_W-1:0] PREV_IX = IDX_W'(PRE_LEN - 2);
  localparam logic [NIB_W-1:0] FILL_V  = NIB_W'(PRE_NIB);
  localparam logic [NIB_W-1:0] DELIM_V = NIB_W'(SFD_NIB);

  logic [IDX_W-1:0] idx;

  assign last = active & (idx == LAST_IX);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
      nibble <= '0;
    end else if (abort) begin
      active <= 1'b0;
      nibble <= '0;
    end else if (load) begin
      active <= 1'b1;
      idx    <= '0;
      nibble <= FILL_V;
    end else if (active) begin
      if (idx == LAST_IX) begin
        active <= 1'b0;
        nibble <= '0;
      end else begin
        idx    <= idx + 1'b1;
        nibble <= (idx == PREV_IX) ? DELIM_V : FILL_V;
      end
    end
  end

  // R9
  delim_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    (active && nibble == DELIM_V) |-> (idx == LAST_IX));
endmodule

// File: rtl/mii_tx_start_gate.sv
module mii_tx_start_gate #(
  parameter int         CNT_W   = 10,
  parameter int         NIB_W   = 4,
  parameter int         PRE_LEN = 16,
  parameter logic [3:0] PRE_NIB = 4'h5,
  parameter logic [3:0] SFD_NIB = 4'hD
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_enable,
  input  logic             self_clr_mode,
  input  logic             auto_pre_en,
  input  logic [CNT_W-1:0] start_dly,
  input  logic [CNT_W-1:0] min_ipg,
  input  logic             rx_dv,
  input  logic             cmp_permit,
  input  logic             fifo_empty,
  input  logic             fifo_eof,
  output logic             tx_en,
  output logic             tx_start,
  output logic             fifo_rd,
  output logic             pre_sel,
  output logic [NIB_W-1:0] pre_nibble,
  output logic             en_clr
);
  import mtg_pkg::*;

  gate_state_e state, state_nxt;
  logic dv_rise, dly_ok, ipg_ok, pre_last;
  logic go, stop, eof_done, tx_en_nxt, permit_ok;

  mtg_delay_timer #(.CNT_W(CNT_W)) u_dly (
    .clk(clk), .rst(rst), .rx_dv(rx_dv), .dly_cfg(start_dly),
    .dv_rise(dv_rise), .expired(dly_ok)
  );

  mtg_ipg_timer #(.CNT_W(CNT_W)) u_ipg (
    .clk(clk), .rst(rst), .tx_en_nxt(tx_en_nxt), .ipg_cfg(min_ipg),
    .expired(ipg_ok)
  );

  mtg_preamble #(
    .NIB_W(NIB_W), .PRE_LEN(PRE_LEN), .PRE_NIB(PRE_NIB), .SFD_NIB(SFD_NIB)
  ) u_pre (
    .clk(clk), .rst(rst), .load(go & auto_pre_en), .abort(stop),
    .active(pre_sel), .nibble(pre_nibble), .last(pre_last)
  );

  assign permit_ok = ~self_clr_mode | cmp_permit;
  assign go        = (state == GATE_IDLE) & tx_enable & ~fifo_empty & ipg_ok
                   & dly_ok & ~dv_rise & permit_ok;
  assign stop      = (state != GATE_IDLE) & ~tx_enable;
  assign fifo_rd   = (state == GATE_DATA) & tx_enable & ~fifo_empty;
  assign eof_done  = fifo_rd & fifo_eof;

  always_comb begin
    state_nxt = state;
    unique case (state)
      GATE_IDLE: if (go) state_nxt = auto_pre_en ? GATE_PRE : GATE_DATA;
      GATE_PRE: begin
        if (stop)          state_nxt = GATE_IDLE;
        else if (pre_last) state_nxt = GATE_DATA;
      end
      GATE_DATA: begin
        if (stop)          state_nxt = GATE_IDLE;
        else if (eof_done) state_nxt = GATE_IDLE;
      end
      default: state_nxt = GATE_IDLE;
    endcase
  end

  assign tx_en_nxt = (state_nxt != GATE_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= GATE_IDLE;
      tx_en    <= 1'b0;
      tx_start <= 1'b0;
      en_clr   <= 1'b0;
    end else begin
      state    <= state_nxt;
      tx_en    <= tx_en_nxt;
      tx_start <= go;
      en_clr   <= eof_done & self_clr_mode;
    end
  end

  // R10
  start_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> (tx_en && !$past(tx_en)));
  // R3
  start_needs_data_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> !$past(fifo_empty));
  // R5
  start_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> $past(tx_enable));
  // R6
  start_needs_permit_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_en) && $past(self_clr_mode)) |-> $past(cmp_permit));
  // R8
  end_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |-> $past(!tx_enable || (fifo_rd && fifo_eof)));
  // R7
  clr_single_chk: assert property (@(posedge clk) disable iff (rst)
    en_clr |=> !en_clr);
  // R9
  no_read_in_pre_chk: assert property (@(posedge clk) disable iff (rst)
    pre_sel |-> !fifo_rd);
endmodule

// File: tb/tb_mii_tx_start_gate.sv
module tb_mii_tx_start_gate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_enable = 0, self_clr_mode = 0, auto_pre_en = 0;
  logic [9:0] start_dly = 10'h40, min_ipg = 10'h28;
  logic rx_dv = 0, cmp_permit = 0, fifo_empty = 1, fifo_eof = 0;
  logic tx_en, tx_start, fifo_rd, pre_sel, en_clr;
  logic [3:0] pre_nibble;

  always #4 clk = ~clk;

  mii_tx_start_gate dut (
    .clk(clk), .rst(rst), .tx_enable(tx_enable), .self_clr_mode(self_clr_mode),
    .auto_pre_en(auto_pre_en), .start_dly(start_dly), .min_ipg(min_ipg),
    .rx_dv(rx_dv), .cmp_permit(cmp_permit), .fifo_empty(fifo_empty),
    .fifo_eof(fifo_eof), .tx_en(tx_en), .tx_start(tx_start), .fifo_rd(fifo_rd),
    .pre_sel(pre_sel), .pre_nibble(pre_nibble), .en_clr(en_clr)
  );

  int n_cmp = 0, n_bad = 0, n_clr = 0;
  bit finished = 0, pend = 0;
  logic [4:0] fq[$];

  // behavioural reference
  int m_state = 0, m_pidx = 0, m_dly = 0, m_ipg = 1023;
  bit m_dvq = 0, m_en = 0, m_st = 0, m_pre = 0, m_clr = 0;
  int m_nib = 0;

  always @(posedge clk) begin
    bit rise, rd, go, halt;
    if (rst) begin
      m_state = 0; m_pidx = 0; m_dly = 0; m_ipg = 1023; m_dvq = 0;
      m_en = 0; m_st = 0; m_pre = 0; m_clr = 0; m_nib = 0;
    end else begin
      rise = rx_dv && !m_dvq;
      rd   = (m_state == 2) && tx_enable && !fifo_empty;
      halt = (m_state != 0) && !tx_enable;
      go   = (m_state == 0) && tx_enable && !fifo_empty && (m_ipg >= min_ipg)
             && (m_dly == 0) && !rise && (!self_clr_mode || cmp_permit);
      m_st = go; m_clr = 0;
      if (halt) begin
        m_state = 0; m_en = 0; m_pre = 0; m_nib = 0;
      end else if (m_state == 0) begin
        if (go) begin
          m_en = 1;
          if (auto_pre_en) begin m_state = 1; m_pidx = 0; m_pre = 1; m_nib = 5; end
          else m_state = 2;
        end
      end else if (m_state == 1) begin
        if (m_pidx == 15) begin m_state = 2; m_pre = 0; m_nib = 0; end
        else begin m_pidx++; m_nib = (m_pidx == 15) ? 13 : 5; end
      end else if (rd && fifo_eof) begin
        m_state = 0; m_en = 0; m_clr = self_clr_mode;
      end
      if (m_en) m_ipg = 0; else if (m_ipg < min_ipg) m_ipg++;
      if (rise) m_dly = start_dly; else if (m_dly > 0) m_dly--;
      m_dvq = rx_dv;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic refresh;
    fifo_empty = (fq.size() == 0);
    fifo_eof   = fifo_empty ? 1'b0 : fq[0][4];
  endtask

  task automatic tick;
    @(negedge clk);
    if (pend) begin
      if (fq.size() > 0) void'(fq.pop_front());
      pend = 0;
    end
    refresh();
    #1;
    if (!rst) begin
      chk("R8 tx_en", int'(tx_en), int'(m_en));
      chk("R10 tx_start", int'(tx_start), int'(m_st));
      chk("R11 fifo_rd", int'(fifo_rd),
          int'((m_state == 2) && tx_enable && !fifo_empty));
      chk("R9 pre_sel", int'(pre_sel), int'(m_pre));
      chk("R9 pre_nibble", int'(pre_nibble), m_nib);
      chk("R7 en_clr", int'(en_clr), int'(m_clr));
      pend = fifo_rd;
      if (en_clr) begin n_clr++; tx_enable = 0; end
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic push_frame(input int n);
    for (int i = 0; i < n; i++) fq.push_back({(i == n - 1), 4'(i)});
    refresh();
  endtask

  task automatic drain;
    while (tx_en) tick();
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    summary();
  end

  initial begin
    int n, reads, prec;
    int nibs[$];
    ticks(3);
    // R1
    chk("R1 tx_en", int'(tx_en), 0);
    chk("R1 tx_start", int'(tx_start), 0);
    chk("R1 pre_sel", int'(pre_sel), 0);
    chk("R1 en_clr", int'(en_clr), 0);
    chk("R1 pre_nibble", int'(pre_nibble), 0);
    rst = 0;
    tick();
    chk("R1 idle after reset", int'(tx_en), 0);

    // R3: enabled but FIFO empty
    tx_enable = 1;
    ticks(5);
    chk("R3 no start while empty", int'(tx_en), 0);
    push_frame(6);
    n = 0;
    while (!tx_en) begin tick(); n++; end
    chk("R3 start at first non-empty edge", n, 1);
    chk("R6 permit ignored when mode off", int'(tx_en), 1);
    reads = 0;
    while (tx_en) begin reads += int'(fifo_rd); tick(); end
    chk("R8 nibbles read per frame", reads, 6);
    chk("R11 no preamble select", int'(pre_sel), 0);

    // R4: gap from tx_en fall
    push_frame(3);
    n = 0;
    while (!tx_en) begin tick(); n++; end
    chk("R4 minimum gap cycles", n, 40);
    drain();

    // R2: start delay after rx_dv
    start_dly = 10'd20;
    ticks(50);
    push_frame(2);
    rx_dv = 1;
    n = 0;
    while (!tx_en) begin tick(); n++; end
    chk("R2 start delay edges", n, 22);
    drain();
    rx_dv = 0;

    // R5: enable gating and immediate stop
    tx_enable = 0;
    push_frame(8);
    ticks(60);
    chk("R5 no start while disabled", int'(tx_en), 0);
    tx_enable = 1;
    tick();
    chk("R5 start on enable", int'(tx_en), 1);
    ticks(2);
    tx_enable = 0;
    #1;
    chk("R5 read stops at once", int'(fifo_rd), 0);
    tick();
    chk("R5 tx_en drops next edge", int'(tx_en), 0);
    fq.delete();
    refresh();

    // R9: automatic preamble
    ticks(50);
    auto_pre_en = 1;
    tx_enable = 1;
    push_frame(4);
    while (!tx_en) tick();
    prec = 0;
    while (pre_sel) begin
      nibs.push_back(int'(pre_nibble));
      chk("R9 no read during preamble", int'(fifo_rd), 0);
      prec++;
      tick();
    end
    chk("R9 preamble length", prec, 16);
    for (int i = 0; i < nibs.size(); i++)
      chk("R9 preamble nibble", nibs[i], (i == 15) ? 13 : 5);
    reads = 0;
    while (tx_en) begin reads += int'(fifo_rd); tick(); end
    chk("R9 data after preamble", reads, 4);
    auto_pre_en = 0;

    // R6 / R7: permit and self-clear
    ticks(50);
    chk("R7 no clear when mode off", n_clr, 0);
    self_clr_mode = 1;
    cmp_permit = 0;
    push_frame(3);
    tx_enable = 1;
    ticks(30);
    chk("R6 held without permit", int'(tx_en), 0);
    cmp_permit = 1;
    tick();
    chk("R6 start with permit", int'(tx_en), 1);
    while (tx_en) tick();
    chk("R7 clear with end of frame", int'(en_clr), 1);
    tick();
    chk("R7 clear is single pulse", int'(en_clr), 0);
    chk("R7 clear count", n_clr, 1);
    push_frame(3);
    ticks(60);
    chk("R7 no restart after self clear", int'(tx_en), 0);

    summary();
  end
endmodule